// File: doc/BRIEF.md
# E1 Resynchronization Criteria Monitor

This block sits beside an E1 receive framer and watches the outcome of every alignment check the framer makes. For each checked frame alignment word, each checked signalling multiframe alignment word and each checked CRC-4 code word, the framer pulses a valid strobe together with an error bit. The monitor applies a separate loss criterion at each of the three levels. When a criterion is met, it latches an event flag.

The three criteria run in parallel and independently. The frame level fires on three erroneous words in a row. The signalling multiframe level fires on two erroneous words in a row. The CRC-4 level counts erroneous code words inside fixed windows of 1000 code words and fires once a window holds 915 of them. The flags are packed into one status byte. Software reads this byte through a small register port and clears single flags by writing ones to them. The framer's own search, bit slicing and CRC arithmetic belong to other blocks.

Top module: `e1_resync_monitor`

## Requirements
- R1: The frame-level event (status bit 1) is set on the clock edge that accepts the third frame alignment word received in error in an unbroken run of erroneous frame words. Cycles without a frame strobe do not break the run.
- R2: The multiframe-level event (status bit 0) is set on the clock edge that accepts the second signalling multiframe alignment word received in error in an unbroken run.
- R3: The CRC-level event (status bit 2) is set on the clock edge that accepts the 915th erroneous CRC-4 code word within the current window of 1000 code words. The error count returns to zero when a window of 1000 code words closes.
- R4: Reading the status address (STATUS_ADDR, default 2) returns the three event bits in bits 2:0, with bits 7:3 always zero. Reading any other address returns zero.
- R5: Reset, which is synchronous and active low, clears all event bits and all counters.
- R6: A word received without error on a level resets the consecutive-error run of that level to zero.
- R7: An event bit stays set until a write to STATUS_ADDR carries a one in its bit position. Zero bits in the write data, and writes to other addresses, leave the bits unchanged.
- R8: If an event fires in the same cycle as a write that clears it, the bit ends up set.
- R9: Once a criterion fires, its count restarts from zero. A further event on that level needs a complete new run of errors (three frame words, two multiframe words, or 915 code-word errors within a window).
- R10: An error bit presented without its valid strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fas_vld | input | 1 | A frame alignment word was checked this cycle |
| fas_err | input | 1 | The checked frame alignment word was in error |
| cas_vld | input | 1 | A signalling multiframe alignment word was checked this cycle |
| cas_err | input | 1 | The checked multiframe alignment word was in error |
| crc_vld | input | 1 | A CRC-4 code word was checked this cycle |
| crc_err | input | 1 | The checked CRC-4 code word was in error |
| reg_addr | input | ADDR_W (4) | Register address for read and write |
| reg_wr | input | 1 | Write strobe, a one in the data clears an event bit |
| reg_wdata | input | 3 | Clear mask: bit 0 multiframe, bit 1 frame, bit 2 CRC |
| reg_rdata | output | 8 | Combinational read data |

## Verification
On every cycle the assertions check the following. A rising event bit must be traced to an erroneous valid word of its own level in the previous cycle. Uncleared bits must hold. A clear write with no competing error must drop its bit. The upper read bits and reads at foreign addresses must be zero. Reset must empty the status. The counting itself can only be shown by the bench's scenarios and its cycle-level reference model: the exact word on which each criterion fires, run breaks on good words, restarts after a hit, the 914-versus-915 window boundary, and set winning over clear.

// File: rtl/e1rm_pkg.sv
// Package e1rm_pkg
// Shared constants of the resynchronization monitor: the number of event
// levels and the bit position of each level in the status byte.
package e1rm_pkg;
    localparam int EVT_N     = 3;
    localparam int STATUS_W  = 8;
    localparam int BIT_CAS   = 0;
    localparam int BIT_FAS   = 1;
    localparam int BIT_CRC   = 2;
endpackage

// File: rtl/e1rm_run_detect.sv
// Module e1rm_run_detect
// Counts consecutive erroneous words at one alignment level and pulses
// hit on the word that completes a run of RUN_LEN errors.
// Assumes word_err is only meaningful while word_vld is high. A good
// word or a hit restarts the run.
module e1rm_run_detect #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic word_err,
    output logic hit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_q;

    // Criterion met when this erroneous word completes the run
    assign hit = word_vld && word_err && (run_q == CW'(RUN_LEN - 1));

    // Track the length of the current run of erroneous words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (word_vld) begin
            if (!word_err || hit) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/e1rm_window_detect.sv
// Module e1rm_window_detect
// Counts erroneous code words inside fixed windows of WINDOW words and
// pulses hit on the word that brings the window's error count to THRESH.
// Assumes word_err is only meaningful while word_vld is high. The error
// count restarts after a hit and at each window boundary. The window
// position keeps running through a hit.
module e1rm_window_detect #(
    parameter int WINDOW = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic word_err,
    output logic hit
);
    localparam int PW = $clog2(WINDOW);
    localparam int EW = $clog2(THRESH + 1);

    logic [PW-1:0] pos_q;
    logic [EW-1:0] err_q;
    logic          last_word;

    // Marks the final word of the current window
    assign last_word = (pos_q == PW'(WINDOW - 1));

    // Threshold reached by this erroneous word
    assign hit = word_vld && word_err && (err_q == EW'(THRESH - 1));

    // Advance the position inside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (word_vld) begin
            pos_q <= last_word ? '0 : pos_q + 1'b1;
        end
    end

    // Accumulate errors, restarting on a hit or at a window boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (word_vld) begin
            if (last_word || hit) begin
                err_q <= '0;
            end else begin
                err_q <= err_q + {{(EW-1){1'b0}}, word_err};
            end
        end
    end
endmodule

// File: rtl/e1rm_event_reg.sv
// Module e1rm_event_reg
// A row of N sticky event bits. A set pulse latches a bit, and a clear
// pulse drops it. When both arrive together, the set wins.
module e1rm_event_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] evt_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Sticky bit with set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                evt_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                evt_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/e1_resync_monitor.sv
// Module e1_resync_monitor
// Top of the resynchronization criteria monitor. It combines two run
// detectors (frame and signalling multiframe), one window detector (CRC-4)
// and a write-one-to-clear status register with a combinational read port.
// Assumes the framer gives at most one strobe per level per cycle.
module e1_resync_monitor #(
    parameter int                FAS_RUN     = 3,
    parameter int                CAS_RUN     = 2,
    parameter int                CRC_WINDOW  = 1000,
    parameter int                CRC_THRESH  = 915,
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fas_vld,
    input  logic              fas_err,
    input  logic              cas_vld,
    input  logic              cas_err,
    input  logic              crc_vld,
    input  logic              crc_err,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [2:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    import e1rm_pkg::*;

    logic [EVT_N-1:0] set_v;
    logic [EVT_N-1:0] clr_v;
    logic [EVT_N-1:0] evt_q;
    logic             addr_hit;

    e1rm_run_detect #(.RUN_LEN(FAS_RUN)) u_fas (
        .clk(clk), .rst_n(rst_n), .word_vld(fas_vld), .word_err(fas_err),
        .hit(set_v[BIT_FAS])
    );

    e1rm_run_detect #(.RUN_LEN(CAS_RUN)) u_cas (
        .clk(clk), .rst_n(rst_n), .word_vld(cas_vld), .word_err(cas_err),
        .hit(set_v[BIT_CAS])
    );

    e1rm_window_detect #(.WINDOW(CRC_WINDOW), .THRESH(CRC_THRESH)) u_crc (
        .clk(clk), .rst_n(rst_n), .word_vld(crc_vld), .word_err(crc_err),
        .hit(set_v[BIT_CRC])
    );

    // Decode the register access aimed at the status byte
    assign addr_hit = (reg_addr == STATUS_ADDR);

    // Clear mask applies only to writes at the status address
    always_comb begin
        clr_v = (reg_wr && addr_hit) ? reg_wdata : '0;
    end

    e1rm_event_reg #(.N(EVT_N)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .evt_o(evt_q)
    );

    // Present the status byte, upper bits zero, or zero off-address
    always_comb begin
        reg_rdata = '0;
        if (addr_hit) begin
            reg_rdata[EVT_N-1:0] = evt_q;
        end
    end
endmodule

// File: rtl/e1rm_checker.sv
// Module e1rm_checker
// Property checker for e1_resync_monitor, attached through bind. It looks
// at the ports and at the event register of the top.
module e1rm_checker #(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fas_vld,
    input logic              fas_err,
    input logic              cas_vld,
    input logic              cas_err,
    input logic              crc_vld,
    input logic              crc_err,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [2:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic [2:0]        status
);
    logic       wr_hit;
    logic [2:0] clr_m;

    assign wr_hit = reg_wr && (reg_addr == STATUS_ADDR);
    assign clr_m  = wr_hit ? reg_wdata : 3'b000;

    assert_reset_zero_R5: assert property (@(posedge clk)
        !rst_n |=> (status == 3'b000));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:3] == 5'b0);

    assert_off_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != STATUS_ADDR) |-> (reg_rdata == 8'h00));

    assert_cas_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(cas_vld && cas_err));

    assert_fas_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(fas_vld && fas_err));

    assert_crc_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(crc_vld && crc_err));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~clr_m)) |=>
        ((status & $past(status & ~clr_m)) == $past(status & ~clr_m)));

    assert_clear_fas_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m[1] && !(fas_vld && fas_err)) |=> !status[1]);

    assert_clear_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m[0] && !(cas_vld && cas_err)) |=> !status[0]);
endmodule

bind e1_resync_monitor e1rm_checker #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .fas_vld(fas_vld), .fas_err(fas_err),
    .cas_vld(cas_vld), .cas_err(cas_err),
    .crc_vld(crc_vld), .crc_err(crc_err),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status(evt_q)
);

// File: tb/e1_resync_monitor_test.sv
`timescale 1ns/1ps
// Bench e1_resync_monitor_test
// Directed scenarios with literal expectations, plus a behavioural
// reference model compared with the read port on every clock.
module e1_resync_monitor_test;
    localparam logic [3:0] SA = 4'h2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fas_vld = 0, fas_err = 0, cas_vld = 0, cas_err = 0;
    logic       crc_vld = 0, crc_err = 0;
    logic [3:0] reg_addr = SA;
    logic       reg_wr = 0;
    logic [2:0] reg_wdata = 0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    e1_resync_monitor #(.ADDR_W(4), .STATUS_ADDR(SA)) uut (
        .clk(clk), .rst_n(rst_n),
        .fas_vld(fas_vld), .fas_err(fas_err),
        .cas_vld(cas_vld), .cas_err(cas_err),
        .crc_vld(crc_vld), .crc_err(crc_err),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Reference model: run counts, window position and errors, flags
    int         m_fas, m_cas, m_pos, m_err;
    logic [2:0] m_bits = 0;

    always @(posedge clk) begin
        logic [2:0] set_m;
        logic [2:0] clr_m;
        if (!rst_n) begin
            m_fas = 0; m_cas = 0; m_pos = 0; m_err = 0; m_bits = 0;
        end else begin
            set_m = 0;
            if (fas_vld) begin
                if (fas_err) begin
                    m_fas++;
                    if (m_fas == 3) begin set_m[1] = 1; m_fas = 0; end
                end else m_fas = 0;
            end
            if (cas_vld) begin
                if (cas_err) begin
                    m_cas++;
                    if (m_cas == 2) begin set_m[0] = 1; m_cas = 0; end
                end else m_cas = 0;
            end
            if (crc_vld) begin
                if (crc_err) begin
                    m_err++;
                    if (m_err == 915) begin set_m[2] = 1; m_err = 0; end
                end
                m_pos++;
                if (m_pos == 1000) begin m_pos = 0; m_err = 0; end
            end
            clr_m  = (reg_wr && reg_addr == SA) ? reg_wdata : 3'b000;
            m_bits = (m_bits & ~clr_m) | set_m;
        end
    end

    // Compare the read port with the model on every clock (R4 layout)
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (rst_n && !done) begin
            exp_rd = (reg_addr == SA) ? {5'b0, m_bits} : 8'h00;
            checks++;
            if (reg_rdata !== exp_rd) begin
                fails++;
                $display("FAIL R4 model compare at %0t: got %h expected %h",
                         $time, reg_rdata, exp_rd);
            end
        end
    end

    task automatic step(input logic fv, fe, cv, ce, kv, ke, wr,
                        input logic [2:0] wd);
        @(negedge clk); #1;
        fas_vld = fv; fas_err = fe; cas_vld = cv; cas_err = ce;
        crc_vld = kv; crc_err = ke; reg_wr = wr; reg_wdata = wd;
        @(posedge clk); #1;
        fas_vld = 0; fas_err = 0; cas_vld = 0; cas_err = 0;
        crc_vld = 0; crc_err = 0; reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic fas_w(input logic e); step(1, e, 0, 0, 0, 0, 0, 3'b0); endtask
    task automatic cas_w(input logic e); step(0, 0, 1, e, 0, 0, 0, 3'b0); endtask
    task automatic crc_w(input logic e); step(0, 0, 0, 0, 1, e, 0, 3'b0); endtask
    task automatic clr_w(input logic [2:0] m); step(0, 0, 0, 0, 0, 0, 1, m); endtask

    task automatic expect_rd(input string tag, input logic [7:0] exp_v);
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp_v) begin
            fails++;
            $display("FAIL %s: read got %h expected %h", tag, reg_rdata, exp_v);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        expect_rd("R5 reset state", 8'h00);
        #1 rst_n = 1'b1;

        // R2: two erroneous multiframe words
        cas_w(1); expect_rd("R2 one cas error", 8'h00);
        cas_w(1); expect_rd("R2 two cas errors", 8'h01);
        clr_w(3'b001); expect_rd("R7 clear cas", 8'h00);

        // R6: good word breaks the run
        cas_w(1); cas_w(0); cas_w(1); expect_rd("R6 broken cas run", 8'h00);
        cas_w(1); expect_rd("R6 run after good word", 8'h01);
        clr_w(3'b001); expect_rd("R7 clear cas again", 8'h00);

        // R10: error bits without strobes
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 1, 0, 3'b0);
        expect_rd("R10 errors without valid", 8'h00);

        // R1: three frame errors, idle cycle inside the run
        fas_w(1); step(0, 0, 0, 0, 0, 0, 0, 3'b0); fas_w(1);
        expect_rd("R1 two fas errors", 8'h00);
        fas_w(1); expect_rd("R1 three fas errors", 8'h02);

        // R9: a fresh run is needed after the event
        clr_w(3'b010); expect_rd("R7 clear fas", 8'h00);
        fas_w(1); fas_w(1); expect_rd("R9 two errors after restart", 8'h00);
        fas_w(1); expect_rd("R9 third error after restart", 8'h02);

        // R8: set and clear in the same cycle
        clr_w(3'b010);
        fas_w(1); fas_w(1);
        step(1, 1, 0, 0, 0, 0, 1, 3'b010);
        expect_rd("R8 set wins over clear", 8'h02);
        clr_w(3'b001); expect_rd("R7 zero bit keeps fas", 8'h02);
        #1 reg_addr = 4'h5;
        clr_w(3'b111); expect_rd("R4 other address reads zero", 8'h00);
        #1 reg_addr = SA;
        expect_rd("R7 write elsewhere ignored", 8'h02);
        clr_w(3'b111); expect_rd("R7 clear all", 8'h00);

        // R3: 914 errors in a window do not fire; 915 do
        for (int i = 0; i < 914; i++) crc_w(1);
        for (int i = 0; i < 86; i++) crc_w(0);
        expect_rd("R3 914 errors in window", 8'h00);
        for (int i = 0; i < 914; i++) crc_w(1);
        expect_rd("R3 914 errors second window", 8'h00);
        crc_w(1); expect_rd("R3 915th error", 8'h04);
        clr_w(3'b100);
        for (int i = 0; i < 85; i++) crc_w(1);
        expect_rd("R9 crc count restarted", 8'h00);
        for (int i = 0; i < 915; i++) crc_w(1);
        expect_rd("R3 full third window", 8'h04);
        clr_w(3'b100);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(r[0], ($urandom % 10) < 6, r[1], ($urandom % 10) < 6,
                 ($urandom % 10) < 9, ($urandom % 100) < 95,
                 ($urandom % 8) == 0, 3'($urandom));
        end

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule